// File: doc/BRIEF.md
# Streaming Error-Vector Remapping Adapter

This block sits between a streaming source and a streaming sink that agree on their data width and their valid/ready handshake but expose different error vectors. It has no state and no clock. Data and valid travel from source to sink on plain wires, and ready travels back from sink to source the same way. The adapter never holds, delays or drops a beat, so back-pressure is whatever the sink applies. A beat moves on any cycle in which `src_valid_i` and `snk_ready_i` are both high.

The sink's error vector is built again, one bit at a time, from two tag tables fixed at elaboration. Each error bit on either side carries an 8-bit tag code. Code 0 means "no type", code 1 is the reserved catch-all ("other"), and codes 2 and above are named types. An output bit with a named tag copies the input bit that has the same tag. An output bit tagged "other" takes the OR of every input bit whose tag no output bit claims. Any other output bit is held low. Either side may have no error vector at all. In that case its port is a single padding bit: an input padding bit is ignored and an output padding bit is held low.

The tag of error bit i sits at bits [8*i+7 : 8*i] of the packed parameter for its side. With the default parameters the adapter maps a six-bit input vector onto a four-bit output vector.

Top module: `stream_errmap_adapter`

## Requirements
- R1: `snk_data_o` equals `src_data_i` and `snk_valid_o` equals `src_valid_i` at all times.
- R2: `src_ready_o` equals `snk_ready_i` at all times, whatever the value of valid, so the adapter adds no buffering and no back-pressure of its own.
- R3: An output bit whose tag is a named code (2 or above) equals the lowest-index input bit that carries the same code.
- R4: An output bit tagged 1 ("other") equals the OR of all live input bits whose tag matches no output bit. Input bits tagged 0 or 1 always count as unmatched.
- R5: When every live input bit is claimed by some output tag, the "other" output bit stays 0.
- R6: An output bit tagged 0, or tagged with a named code that no input bit carries, is always 0.
- R7: With IN_ERR_W = 0, the one-bit input error port is ignored and every output error bit is 0.
- R8: With OUT_ERR_W = 0, the one-bit output error port is always 0.
- R9: With one input bit and one output bit carrying the same named tag, the output bit equals the input bit.
- R10: An all-zero live input error vector yields an all-zero output error vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_data_i | input | DATA_W | Payload from the source |
| src_valid_i | input | 1 | Source has a beat |
| src_ready_o | output | 1 | Back-pressure toward the source |
| src_err_i | input | max(IN_ERR_W,1) | Source error vector (padding bit when IN_ERR_W is 0) |
| snk_data_o | output | DATA_W | Payload to the sink |
| snk_valid_o | output | 1 | Beat offered to the sink |
| snk_ready_i | input | 1 | Sink accepts the beat |
| snk_err_o | output | max(OUT_ERR_W,1) | Remapped error vector (padding bit when OUT_ERR_W is 0) |

## Verification
Every result of this adapter is due in the same cycle as its stimulus, because no register lies on any path. This applies to the forwarded data and valid, the returned ready, and each rebuilt error bit. The bench drives inputs on the falling clock edge and samples the outputs 5 ns later, which is well before the next rising edge. Six instances with different tag tables are checked in this way against a bench function that resolves the tags.

// File: rtl/errmap_pkg.sv
package errmap_pkg;
  // Width of one tag code and the two reserved codes.
  localparam int TAG_W = 8;
  localparam logic [TAG_W-1:0] TAG_NONE  = 8'd0;
  localparam logic [TAG_W-1:0] TAG_OTHER = 8'd1;

  // A zero-width vector is carried as a single padding bit.
  function automatic int pad_w(input int w);
    return (w > 0) ? w : 1;
  endfunction
endpackage

// File: rtl/errmap_stream_wire.sv
module errmap_stream_wire #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] up_data_i,
  input  logic              up_valid_i,
  output logic              up_ready_o,
  output logic [DATA_W-1:0] dn_data_o,
  output logic              dn_valid_o,
  input  logic              dn_ready_i
);
  // Forward path and backward path are plain wires: no beat is held.
  assign dn_data_o  = up_data_i;
  assign dn_valid_o = up_valid_i;
  assign up_ready_o = dn_ready_i;
endmodule

// File: rtl/errmap_collect.sv
module errmap_collect import errmap_pkg::*; #(
  parameter int IN_W  = 6,
  parameter int OUT_W = 4,
  parameter logic [pad_w(IN_W)*TAG_W-1:0]  IN_TAGS  = '0,
  parameter logic [pad_w(OUT_W)*TAG_W-1:0] OUT_TAGS = '0
) (
  input  logic [pad_w(IN_W)-1:0] err_i,
  output logic                   other_o
);
  localparam int IPW = pad_w(IN_W);

  // An input bit is claimed when some output bit carries its named tag.
  function automatic logic [IPW-1:0] claim_mask();
    logic [IPW-1:0]   m;
    logic [TAG_W-1:0] t;
    m = '0;
    for (int i = 0; i < IN_W; i++) begin
      t = IN_TAGS[i*TAG_W +: TAG_W];
      if (t != TAG_NONE && t != TAG_OTHER) begin
        for (int o = 0; o < OUT_W; o++) begin
          if (OUT_TAGS[o*TAG_W +: TAG_W] == t) m[i] = 1'b1;
        end
      end
    end
    return m;
  endfunction

  localparam logic [IPW-1:0] CLAIMED = claim_mask();
  // The padding bit of an absent input vector is never live.
  localparam logic [IPW-1:0] LIVE    = (IN_W > 0) ? {IPW{1'b1}} : {IPW{1'b0}};
  localparam logic [IPW-1:0] SPARE   = LIVE & ~CLAIMED;

  assign other_o = |(err_i & SPARE);
endmodule

// File: rtl/errmap_bit_route.sv
module errmap_bit_route import errmap_pkg::*; #(
  parameter int IN_W = 6,
  parameter logic [TAG_W-1:0] MY_TAG = TAG_NONE,
  parameter logic [pad_w(IN_W)*TAG_W-1:0] IN_TAGS = '0
) (
  input  logic [pad_w(IN_W)-1:0] err_i,
  input  logic                   other_i,
  output logic                   bit_o
);
  localparam int IPW = pad_w(IN_W);
  localparam bit IS_OTHER = (MY_TAG == TAG_OTHER);
  localparam bit IS_NAMED = !IS_OTHER && (MY_TAG != TAG_NONE);

  // One-hot select of the lowest-index input with the same named tag.
  function automatic logic [IPW-1:0] pick_mask();
    logic [IPW-1:0] m;
    m = '0;
    if (IS_NAMED) begin
      for (int i = IN_W - 1; i >= 0; i--) begin
        if (IN_TAGS[i*TAG_W +: TAG_W] == MY_TAG) begin
          m    = '0;
          m[i] = 1'b1;
        end
      end
    end
    return m;
  endfunction

  localparam logic [IPW-1:0] PICK = pick_mask();

  generate
    if (IS_OTHER) begin : g_other
      assign bit_o = other_i | (|(err_i & PICK));
    end else begin : g_copy
      // An empty PICK leaves the bit tied low.
      assign bit_o = (|(err_i & PICK)) | (other_i & 1'b0);
    end
  endgenerate
endmodule

// File: rtl/stream_errmap_adapter.sv
module stream_errmap_adapter import errmap_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int IN_ERR_W  = 6,
  parameter int OUT_ERR_W = 4,
  // Default input tags, bit 5..0: 7,6,5,3,2,4
  parameter logic [pad_w(IN_ERR_W)*TAG_W-1:0]  IN_TAGS  = 48'h07_06_05_03_02_04,
  // Default output tags, bit 3..0: 4,2,other,8
  parameter logic [pad_w(OUT_ERR_W)*TAG_W-1:0] OUT_TAGS = 32'h04_02_01_08
) (
  input  logic [DATA_W-1:0]           src_data_i,
  input  logic                        src_valid_i,
  output logic                        src_ready_o,
  input  logic [pad_w(IN_ERR_W)-1:0]  src_err_i,
  output logic [DATA_W-1:0]           snk_data_o,
  output logic                        snk_valid_o,
  input  logic                        snk_ready_i,
  output logic [pad_w(OUT_ERR_W)-1:0] snk_err_o
);
  logic spare_or;

  errmap_stream_wire #(.DATA_W(DATA_W)) u_wire (
    .up_data_i  (src_data_i),
    .up_valid_i (src_valid_i),
    .up_ready_o (src_ready_o),
    .dn_data_o  (snk_data_o),
    .dn_valid_o (snk_valid_o),
    .dn_ready_i (snk_ready_i)
  );

  errmap_collect #(
    .IN_W(IN_ERR_W), .OUT_W(OUT_ERR_W), .IN_TAGS(IN_TAGS), .OUT_TAGS(OUT_TAGS)
  ) u_collect (
    .err_i   (src_err_i),
    .other_o (spare_or)
  );

  generate
    if (OUT_ERR_W == 0) begin : g_no_out
      assign snk_err_o = 1'b0 & spare_or;
    end else begin : g_out
      for (genvar o = 0; o < OUT_ERR_W; o++) begin : g_bit
        errmap_bit_route #(
          .IN_W(IN_ERR_W),
          .MY_TAG(OUT_TAGS[o*TAG_W +: TAG_W]),
          .IN_TAGS(IN_TAGS)
        ) u_route (
          .err_i   (src_err_i),
          .other_i (spare_or),
          .bit_o   (snk_err_o[o])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/errmap_checker.sv
module errmap_checker import errmap_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int IN_ERR_W  = 6,
  parameter int OUT_ERR_W = 4
) (
  input logic [DATA_W-1:0]           src_data_i,
  input logic                        src_valid_i,
  input logic                        src_ready_o,
  input logic [pad_w(IN_ERR_W)-1:0]  src_err_i,
  input logic [DATA_W-1:0]           snk_data_o,
  input logic                        snk_valid_o,
  input logic                        snk_ready_i,
  input logic [pad_w(OUT_ERR_W)-1:0] snk_err_o
);
  localparam int IPW = pad_w(IN_ERR_W);
  localparam logic [IPW-1:0] LIVE = (IN_ERR_W > 0) ? {IPW{1'b1}} : {IPW{1'b0}};

  always_comb begin
    assert_data_pass_R1: assert (snk_data_o == src_data_i && snk_valid_o == src_valid_i)
      else $error("data or valid not forwarded");
    assert_ready_back_R2: assert (src_ready_o == snk_ready_i)
      else $error("ready not returned");
    assert_quiet_out_R10: assert (((src_err_i & LIVE) != '0) || (snk_err_o == '0))
      else $error("error raised from quiet input");
    assert_err_has_cause_R4: assert ((snk_err_o == '0) || ((src_err_i & LIVE) != '0))
      else $error("output error without any input error");
    if (IN_ERR_W == 0) begin
      assert_absent_in_R7: assert (snk_err_o == '0)
        else $error("absent input vector produced an error");
    end
    if (OUT_ERR_W == 0) begin
      assert_absent_out_R8: assert (snk_err_o == '0)
        else $error("output padding bit not low");
    end
  end
endmodule

bind stream_errmap_adapter errmap_checker #(
  .DATA_W(DATA_W), .IN_ERR_W(IN_ERR_W), .OUT_ERR_W(OUT_ERR_W)
) chk_i (
  .src_data_i  (src_data_i),
  .src_valid_i (src_valid_i),
  .src_ready_o (src_ready_o),
  .src_err_i   (src_err_i),
  .snk_data_o  (snk_data_o),
  .snk_valid_o (snk_valid_o),
  .snk_ready_i (snk_ready_i),
  .snk_err_o   (snk_err_o)
);

// File: tb/stream_errmap_adapter_tb_top.sv
module stream_errmap_adapter_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] data;
  logic        valid, ready;
  logic [31:0] m_data;
  logic        m_valid, m_ready;
  logic [5:0] e_i;  logic [3:0] o_i;
  logic       e_z;  logic [1:0] o_z;
  logic       e_w;  logic       o_w;
  logic [1:0] e_c;  logic [2:0] o_c;
  logic [3:0] e_d;  logic [2:0] o_d;
  logic [1:0] e_n;  logic       o_n;
  logic [7:0] u_d [5];  logic u_v [5];  logic u_r [5];

  // Example mapping (defaults)
  stream_errmap_adapter dut_i (
    .src_data_i(data), .src_valid_i(valid), .src_ready_o(m_ready), .src_err_i(e_i),
    .snk_data_o(m_data), .snk_valid_o(m_valid), .snk_ready_i(ready), .snk_err_o(o_i));
  // No input vector; outputs {bit1 tag 2, bit0 other}
  stream_errmap_adapter #(.DATA_W(8), .IN_ERR_W(0), .OUT_ERR_W(2),
    .IN_TAGS(8'h00), .OUT_TAGS(16'h02_01)) dut_z (
    .src_data_i(data[7:0]), .src_valid_i(valid), .src_ready_o(u_r[0]), .src_err_i(e_z),
    .snk_data_o(u_d[0]), .snk_valid_o(u_v[0]), .snk_ready_i(ready), .snk_err_o(o_z));
  // One-bit wire, tag 5 both sides
  stream_errmap_adapter #(.DATA_W(8), .IN_ERR_W(1), .OUT_ERR_W(1),
    .IN_TAGS(8'h05), .OUT_TAGS(8'h05)) dut_w (
    .src_data_i(data[7:0]), .src_valid_i(valid), .src_ready_o(u_r[1]), .src_err_i(e_w),
    .snk_data_o(u_d[1]), .snk_valid_o(u_v[1]), .snk_ready_i(ready), .snk_err_o(o_w));
  // All inputs claimed: in {b=3,a=2}, out {a=2,other,b=3}
  stream_errmap_adapter #(.DATA_W(8), .IN_ERR_W(2), .OUT_ERR_W(3),
    .IN_TAGS(16'h03_02), .OUT_TAGS(24'h02_01_03)) dut_c (
    .src_data_i(data[7:0]), .src_valid_i(valid), .src_ready_o(u_r[2]), .src_err_i(e_c),
    .snk_data_o(u_d[2]), .snk_valid_o(u_v[2]), .snk_ready_i(ready), .snk_err_o(o_c));
  // Duplicates: in {other,none,a,a}, out {none,other,a}
  stream_errmap_adapter #(.DATA_W(8), .IN_ERR_W(4), .OUT_ERR_W(3),
    .IN_TAGS(32'h01_00_02_02), .OUT_TAGS(24'h00_01_02)) dut_d (
    .src_data_i(data[7:0]), .src_valid_i(valid), .src_ready_o(u_r[3]), .src_err_i(e_d),
    .snk_data_o(u_d[3]), .snk_valid_o(u_v[3]), .snk_ready_i(ready), .snk_err_o(o_d));
  // No output vector
  stream_errmap_adapter #(.DATA_W(8), .IN_ERR_W(2), .OUT_ERR_W(0),
    .IN_TAGS(16'h03_02), .OUT_TAGS(8'h00)) dut_n (
    .src_data_i(data[7:0]), .src_valid_i(valid), .src_ready_o(u_r[4]), .src_err_i(e_n),
    .snk_data_o(u_d[4]), .snk_valid_o(u_v[4]), .snk_ready_i(ready), .snk_err_o(o_n));

  // Reference: resolve tags for each output bit.
  function automatic logic [7:0] model(input logic [7:0] e, input int iw, input logic [63:0] it,
                                       input int ow, input logic [63:0] ot);
    logic [7:0] r = '0;
    for (int o = 0; o < ow; o++) begin
      logic [7:0] t = ot[o*8 +: 8];
      if (t == 8'd1) begin
        for (int i = 0; i < iw; i++) begin
          bool_claim: begin
            bit hit = 1'b0;
            logic [7:0] s = it[i*8 +: 8];
            for (int k = 0; k < ow; k++)
              if (s >= 8'd2 && ot[k*8 +: 8] == s) hit = 1'b1;
            if (!hit) r[o] = r[o] | e[i];
          end
        end
      end else if (t >= 8'd2) begin
        bit found = 1'b0;
        for (int i = 0; i < iw; i++)
          if (!found && it[i*8 +: 8] == t) begin r[o] = e[i]; found = 1'b1; end
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [5:0] ei, input logic ez, input logic ew,
                       input logic [1:0] ec, input logic [3:0] ed, input logic [1:0] en);
    @(negedge clk);
    e_i = ei; e_z = ez; e_w = ew; e_c = ec; e_d = ed; e_n = en;
    #5;
  endtask

  task automatic check_all();
    check("R1 data", m_data, data);
    check("R1 valid", {31'd0, m_valid}, {31'd0, valid});
    check("R2 ready", {31'd0, m_ready}, {31'd0, ready});
    check("R3 R4 R6 example", {28'd0, o_i}, {24'd0, model({2'b0, e_i}, 6, 64'h07_06_05_03_02_04, 4, 64'h04_02_01_08)});
    check("R7 absent input", {30'd0, o_z}, 32'd0);
    check("R9 single wire", {31'd0, o_w}, {31'd0, e_w});
    check("R5 all claimed", {29'd0, o_c}, {24'd0, model({6'b0, e_c}, 2, 64'h03_02, 3, 64'h02_01_03)});
    check("R3 R4 duplicates", {29'd0, o_d}, {24'd0, model({4'b0, e_d}, 4, 64'h01_00_02_02, 3, 64'h00_01_02)});
    check("R8 absent output", {31'd0, o_n}, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    data = 32'hA5A5_0001; valid = 1'b0; ready = 1'b1;
    // R10: quiet inputs give quiet outputs
    drive('0, 1'b1, 1'b0, '0, '0, '0);
    check("R10 quiet", {28'd0, o_i}, 32'd0);
    check("R7 padding ignored", {30'd0, o_z}, 32'd0);
    check("R2 ready with valid low", {31'd0, m_ready}, 32'd1);
    // R3: in0 (tag 4) to out3, in1 (tag 2) to out2
    drive(6'b000001, 1'b0, 1'b1, 2'b00, 4'b0000, 2'b11);
    check("R3 in0 to out3", {28'd0, o_i}, 32'h8);
    check("R9 wire high", {31'd0, o_w}, 32'd1);
    check("R8 pad low", {31'd0, o_n}, 32'd0);
    drive(6'b000010, 1'b0, 1'b0, 2'b00, 4'b0000, 2'b00);
    check("R3 in1 to out2", {28'd0, o_i}, 32'h4);
    // R4: each unclaimed input alone reaches out1
    for (int k = 2; k < 6; k++) begin
      drive(6'(1 << k), 1'b0, 1'b0, 2'b00, 4'b0000, 2'b00);
      check("R4 unclaimed to other", {28'd0, o_i}, 32'h2);
    end
    // R6: out0 never rises even with all inputs set
    drive(6'b111111, 1'b1, 1'b1, 2'b11, 4'b1111, 2'b11);
    check("R6 all inputs set", {28'd0, o_i}, 32'hE);
    check("R5 other stays low", {29'd0, o_c}, 32'h5);
    // dut_d: in1 shares tag a with in0 but only in0 is copied; in1 is claimed, not other
    drive('0, 1'b0, 1'b0, 2'b00, 4'b0010, 2'b00);
    check("R3 lowest index wins", {29'd0, o_d}, 32'd0);
    drive('0, 1'b0, 1'b0, 2'b00, 4'b0100, 2'b00);
    check("R4 none-tagged input to other", {29'd0, o_d}, 32'h2);
    drive('0, 1'b0, 1'b0, 2'b00, 4'b1001, 2'b00);
    check("R4 R6 other-tagged input", {29'd0, o_d}, 32'h3);
    // Random phase
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      data = $urandom; valid = 1'($urandom); ready = 1'($urandom);
      e_i = 6'($urandom); e_z = 1'($urandom); e_w = 1'($urandom);
      e_c = 2'($urandom); e_d = 4'($urandom); e_n = 2'($urandom);
      #5;
      check_all();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule